// File: doc/BRIEF.md
# LPC Host SYNC-Phase Monitor

This block sits on the host side of a 4-bit multiplexed LPC bus. After the turnaround, the cycle sequencer hands control to it with a start pulse. The start pulse also gives the transfer direction and the number of bytes. The monitor then samples the bus nibble on every clock and sorts it into one of five kinds: ready, short wait, long wait, error or no valid SYNC.

It counts short-wait clocks against a cap and counts consecutive clocks with no valid SYNC against a three-clock limit. Long waits may go on without any limit. On a read it takes the two data nibbles that follow a ready or error SYNC, low nibble first.

A multi-byte transfer is followed byte by byte, and each byte ends with a one-cycle pulse. The cycle ends in one of two ways:
- a one-cycle done pulse, with the error flag showing whether an error SYNC was seen;
- a one-cycle abort pulse.

An error SYNC ends the transfer after the current byte, so no later byte is attempted.

Top module: `lpc_sync_mon`

## Requirements
- R1: While reset is asserted, and after it is released until a start pulse, done, abort, byte-done and the error flag stay 0 and read data reads 0. Bus nibbles seen while idle have no effect.
- R2: On a write, a ready SYNC (0000) seen on a clock gives a one-cycle byte-done pulse and, on the last byte, a one-cycle done pulse in the cycle after that clock.
- R3: On a read, after a ready SYNC the bus nibble of the next clock becomes read data bits [3:0] and the nibble of the clock after that becomes bits [7:4]. Byte-done (and done on the last byte) pulses in the cycle after the high nibble.
- R4: Up to 8 short-wait SYNC clocks (0101) per byte are accepted. A ninth short-wait clock for the same byte gives an abort pulse in the following cycle and returns the monitor to idle.
- R5: Long-wait SYNC (0110) clocks never cause an abort, however many are seen.
- R6: Any nibble other than 0000, 0101, 0110 or 1010 counts as no valid SYNC. The third such clock in a row gives an abort pulse, and any valid SYNC restarts this count.
- R7: On a write, an error SYNC (1010) ends the cycle with done and the error flag in the next cycle. The error flag stays 1 until the next accepted start.
- R8: On a read, an error SYNC still captures the next two nibbles as data. The cycle then ends with done, and the error flag is set.
- R9: A transfer of nbytes_i+1 bytes (1 to 4) gives one byte-done per byte, and done only with the last one. An error SYNC on any byte makes that byte the last one.
- R10: Done and abort are single-cycle pulses and never occur together. A start pulse during an active cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin the SYNC phase of a cycle (accepted only when idle) |
| is_read_i | input | 1 | 1 = read (data follows each SYNC), 0 = write |
| nbytes_i | input | 2 | Number of bytes minus one |
| lad_i | input | 4 | Bus nibble sampled every clock |
| done_o | output | 1 | One-cycle pulse: cycle completed |
| abort_o | output | 1 | One-cycle pulse: cycle aborted by a timeout or the short-wait cap |
| err_o | output | 1 | Error SYNC seen in the current or most recent cycle |
| byte_done_o | output | 1 | One-cycle pulse per finished byte |
| rdata_o | output | 8 | Last read data byte |

## Verification
A wait counter that does not clear correctly shows up as an abort pulse one clock too early or too late. The bench finds that edge by sweeping the number of short waits and every possible nibble value. A wrong byte counter or a lost error state shows up at the byte-done and done pulses of a multi-byte read: the pulse count or the position of done differs from what the error position predicts. This is visible within the cycle of the byte where the two disagree. A nibble captured in the wrong order or on the wrong clock shows up in read data at the byte-done pulse of that same byte.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;
  localparam logic [3:0] CODE_READY = 4'b0000;
  localparam logic [3:0] CODE_SHORT = 4'b0101;
  localparam logic [3:0] CODE_LONG  = 4'b0110;
  localparam logic [3:0] CODE_ERROR = 4'b1010;

  typedef enum logic [2:0] {
    SK_READY, SK_SHORT, SK_LONG, SK_ERROR, SK_NONE
  } sync_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SYNC, ST_DLO, ST_DHI
  } mon_state_e;
endpackage

// File: rtl/lpc_rst_sync.sv
module lpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpc_sync_classify.sv
module lpc_sync_classify
  import lpc_sync_pkg::*;
(
  input  logic [3:0]  nib,
  output sync_kind_e  kind
);
  always_comb begin
    unique case (nib)
      CODE_READY: kind = SK_READY;
      CODE_SHORT: kind = SK_SHORT;
      CODE_LONG:  kind = SK_LONG;
      CODE_ERROR: kind = SK_ERROR;
      default:    kind = SK_NONE;
    endcase
  end
endmodule

// File: rtl/lpc_sync_wait_ctr.sv
module lpc_sync_wait_ctr
  import lpc_sync_pkg::*;
#(
  parameter int SHORT_MAX    = 8,
  parameter int NOSYNC_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       active,
  input  sync_kind_e kind,
  output logic       short_over,
  output logic       nosync_hit
);
  localparam int SW = $clog2(SHORT_MAX + 1);
  localparam int NW = (NOSYNC_LIMIT > 2) ? $clog2(NOSYNC_LIMIT) : 1;
  localparam logic [SW-1:0] SHORT_TOP  = SW'(SHORT_MAX);
  localparam logic [NW-1:0] NOSYNC_TOP = NW'(NOSYNC_LIMIT - 1);

  logic [SW-1:0] short_q, short_d;
  logic [NW-1:0] nosync_q, nosync_d;

  assign short_over = active && (kind == SK_SHORT) && (short_q == SHORT_TOP);
  assign nosync_hit = active && (kind == SK_NONE) && (nosync_q == NOSYNC_TOP);

  always_comb begin
    short_d  = short_q;
    nosync_d = nosync_q;
    if (clr) begin
      short_d  = '0;
      nosync_d = '0;
    end else if (active) begin
      if (kind == SK_SHORT && !short_over) short_d = short_q + 1'b1;
      if (kind == SK_NONE) begin
        if (!nosync_hit) nosync_d = nosync_q + 1'b1;
      end else begin
        nosync_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q  <= '0;
      nosync_q <= '0;
    end else begin
      short_q  <= short_d;
      nosync_q <= nosync_d;
    end
  end

  a_r4_short_bound: assert property (@(posedge clk) disable iff (!rst_n)
    short_q <= SHORT_TOP);
  a_r6_nosync_run: assert property (@(posedge clk) disable iff (!rst_n)
    nosync_hit |-> $past(active && kind == SK_NONE));
endmodule

// File: rtl/lpc_sync_mon.sv
module lpc_sync_mon
  import lpc_sync_pkg::*;
#(
  parameter int MAX_BYTES    = 4,
  parameter int SHORT_MAX    = 8,
  parameter int NOSYNC_LIMIT = 3,
  parameter int RST_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       is_read_i,
  input  logic [1:0] nbytes_i,
  input  logic [3:0] lad_i,
  output logic       done_o,
  output logic       abort_o,
  output logic       err_o,
  output logic       byte_done_o,
  output logic [7:0] rdata_o
);
  localparam int CW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic       rst_ns;
  sync_kind_e kind;
  logic       short_over, nosync_hit, ctr_clr, in_sync;

  mon_state_e    state_q, state_d;
  logic [CW-1:0] left_q, left_d;
  logic          rd_q, rd_d, err_q, err_d;
  logic [7:0]    rdata_q, rdata_d;
  logic          done_q, done_d, abort_q, abort_d, byte_q, byte_d;

  lpc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  lpc_sync_classify u_cls (.nib(lad_i), .kind(kind));

  assign in_sync = (state_q == ST_SYNC);
  assign ctr_clr = !in_sync || (kind == SK_READY);

  lpc_sync_wait_ctr #(.SHORT_MAX(SHORT_MAX), .NOSYNC_LIMIT(NOSYNC_LIMIT)) u_wait (
    .clk(clk), .rst_n(rst_ns), .clr(ctr_clr), .active(in_sync), .kind(kind),
    .short_over(short_over), .nosync_hit(nosync_hit)
  );

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    rd_d    = rd_q;
    err_d   = err_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    abort_d = 1'b0;
    byte_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SYNC;
          rd_d    = is_read_i;
          left_d  = CW'(nbytes_i);
          err_d   = 1'b0;
        end
      end
      ST_SYNC: begin
        if (nosync_hit || short_over) begin
          abort_d = 1'b1;
          state_d = ST_IDLE;
        end else if (kind == SK_READY) begin
          if (rd_q) begin
            state_d = ST_DLO;
          end else begin
            byte_d = 1'b1;
            if (left_q == '0) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              left_d = left_q - 1'b1;
            end
          end
        end else if (kind == SK_ERROR) begin
          err_d = 1'b1;
          if (rd_q) begin
            state_d = ST_DLO;
          end else begin
            byte_d  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_DLO: begin
        rdata_d[3:0] = lad_i;
        state_d      = ST_DHI;
      end
      ST_DHI: begin
        rdata_d[7:4] = lad_i;
        byte_d       = 1'b1;
        if (err_q || left_q == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          left_d  = left_q - 1'b1;
          state_d = ST_SYNC;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      byte_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      rd_q    <= rd_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      abort_q <= abort_d;
      byte_q  <= byte_d;
    end
  end

  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign err_o       = err_q;
  assign byte_done_o = byte_q;
  assign rdata_o     = rdata_q;

  a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_ns)
    !(done_q && abort_q));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_ns)
    done_q |=> !done_q);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_q || abort_q) |-> state_q == ST_IDLE);
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(state_q) != ST_DLO && $past(state_q) != ST_DHI) |-> $stable(rdata_q));
  a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(err_q) |-> $past(kind == SK_ERROR));
  a_r9_stop_after_err: assert property (@(posedge clk) disable iff (!rst_ns)
    err_q |-> state_q != ST_SYNC);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !byte_q);
endmodule

// File: tb/lpc_sync_mon_bench.sv
module lpc_sync_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, is_read_i;
  logic [1:0] nbytes_i;
  logic [3:0] lad_i;
  logic       done_o, abort_o, err_o, byte_done_o;
  logic [7:0] rdata_o;
  int ntests = 0;
  int nfail  = 0;

  always #2 clk = ~clk;

  lpc_sync_mon u_lpc_sync_mon (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_read_i(is_read_i),
    .nbytes_i(nbytes_i), .lad_i(lad_i), .done_o(done_o), .abort_o(abort_o),
    .err_o(err_o), .byte_done_o(byte_done_o), .rdata_o(rdata_o)
  );

  task automatic expect_eq(input string req, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] v);
    lad_i = v;
    @(negedge clk);
  endtask

  task automatic begin_cycle(input logic rd, input int nb);
    start_i   = 1'b1;
    is_read_i = rd;
    nbytes_i  = 2'(nb - 1);
    lad_i     = 4'hF;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic bit is_valid(input int v);
    return (v == 0) || (v == 5) || (v == 6) || (v == 10);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int bytes_seen, errs;
    rst_n = 1'b0; start_i = 1'b1; is_read_i = 1'b0; nbytes_i = 2'd0; lad_i = 4'h0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset even with start and ready on the bus
    expect_eq("R1 done in reset", done_o, 0);
    expect_eq("R1 abort in reset", abort_o, 0);
    expect_eq("R1 err in reset", int'(err_o), 0);
    expect_eq("R1 rdata in reset", rdata_o, 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle ignores invalid nibbles and error codes
    errs = 0;
    for (int i = 0; i < 6; i++) begin
      step(i[0] ? 4'hA : 4'hF);
      errs += int'(abort_o) + int'(done_o) + int'(byte_done_o) + int'(err_o);
    end
    expect_eq("R1 idle ignores bus", errs, 0);

    // R2: write ready
    begin_cycle(1'b0, 1);
    step(4'h0);
    expect_eq("R2 done", done_o, 1);
    expect_eq("R2 byte_done", byte_done_o, 1);
    expect_eq("R2 no err", err_o, 0);
    step(4'hF);
    expect_eq("R10 done single", done_o, 0);

    // R3: read data order, sweep of byte values
    for (int d = 0; d < 256; d += 17) begin
      begin_cycle(1'b1, 1);
      step(4'h0);
      expect_eq("R3 no early done", done_o, 0);
      step(4'(d));
      step(4'(d >> 4));
      expect_eq("R3 done after hi", done_o, 1);
      expect_eq("R3 rdata", rdata_o, d);
    end

    // R4: short-wait cap
    for (int n = 0; n <= 9; n++) begin
      begin_cycle(1'b0, 1);
      for (int i = 0; i < n; i++) begin
        step(4'h5);
        expect_eq($sformatf("R4 abort after %0d short", i + 1), abort_o, (i == 8) ? 1 : 0);
      end
      if (n <= 8) begin
        step(4'h0);
        expect_eq("R4 done after shorts", done_o, 1);
      end
      step(4'hF);
    end

    // R5: long waits are unlimited
    begin_cycle(1'b0, 1);
    errs = 0;
    for (int i = 0; i < 60; i++) begin
      step(4'h6);
      errs += int'(abort_o);
    end
    expect_eq("R5 no abort in long wait", errs, 0);
    step(4'h0);
    expect_eq("R5 done after long", done_o, 1);

    // R6: every nibble value held for three clocks
    for (int v = 0; v < 16; v++) begin
      begin_cycle(1'b0, 1);
      if (v == 0 || v == 10) begin
        step(4'(v));
        expect_eq($sformatf("R6 code %0d ends cycle", v), done_o, 1);
      end else begin
        step(4'(v)); step(4'(v));
        expect_eq($sformatf("R6 code %0d no early abort", v), abort_o, 0);
        step(4'(v));
        expect_eq($sformatf("R6 code %0d abort", v), abort_o, is_valid(v) ? 0 : 1);
        if (is_valid(v)) begin
          step(4'h0);
          expect_eq("R6 done after valid waits", done_o, 1);
        end
      end
      step(4'hF);
    end
    // R6: a valid SYNC restarts the no-SYNC count
    begin_cycle(1'b0, 1);
    step(4'hF); step(4'h3); step(4'h6); step(4'hF); step(4'h1);
    expect_eq("R6 count restarted", abort_o, 0);
    step(4'hE);
    expect_eq("R6 abort after restart", abort_o, 1);
    step(4'hF);

    // R7: write error
    begin_cycle(1'b0, 1);
    step(4'h5);
    step(4'hA);
    expect_eq("R7 done", done_o, 1);
    expect_eq("R7 err", err_o, 1);
    step(4'hF); step(4'hF);
    expect_eq("R7 err held", err_o, 1);
    begin_cycle(1'b0, 1);
    expect_eq("R7 err cleared by start", err_o, 0);
    step(4'h0);

    // R8: read error still captures data
    begin_cycle(1'b1, 1);
    step(4'h6);
    step(4'hA);
    expect_eq("R8 no done at error", done_o, 0);
    step(4'h3);
    step(4'hC);
    expect_eq("R8 done", done_o, 1);
    expect_eq("R8 err", err_o, 1);
    expect_eq("R8 rdata", rdata_o, 8'hC3);

    // R9: multi-byte reads with error at each position
    for (int nb = 1; nb <= 4; nb++) begin
      for (int e = 0; e <= nb; e++) begin
        begin_cycle(1'b1, nb);
        bytes_seen = 0;
        for (int b = 0; b < nb; b++) begin
          step((b == e) ? 4'hA : 4'h0);
          step(4'(b));
          step(4'(nb));
          bytes_seen += int'(byte_done_o);
          expect_eq($sformatf("R9 rdata nb=%0d b=%0d", nb, b), rdata_o, nb * 16 + b);
          expect_eq($sformatf("R9 done nb=%0d e=%0d b=%0d", nb, e, b), done_o,
                    (b == nb - 1 || b == e) ? 1 : 0);
          if (b == e) break;
        end
        step(4'h0); step(4'h0);
        bytes_seen += int'(byte_done_o);
        expect_eq($sformatf("R9 byte count nb=%0d e=%0d", nb, e), bytes_seen,
                  (e < nb) ? e + 1 : nb);
        expect_eq($sformatf("R9 err nb=%0d e=%0d", nb, e), err_o, (e < nb) ? 1 : 0);
      end
    end

    // R10: start while busy is ignored
    begin_cycle(1'b0, 2);
    start_i = 1'b1; is_read_i = 1'b1; nbytes_i = 2'd0;
    step(4'h0);
    expect_eq("R10 first byte, no done", done_o, 0);
    expect_eq("R10 first byte pulse", byte_done_o, 1);
    step(4'h0);
    expect_eq("R10 write done despite start", done_o, 1);
    start_i = 1'b0;
    step(4'hF);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule